// File: doc/BRIEF.md
# Serial Mailbox Program Loader

This block fills an instruction RAM from a host microcontroller after reset. The host sends its program as a stream of 8-bit bytes over a two-wire synchronous serial input, using a serial clock and a data line. It frames each transfer with a request line, and the loader answers on an acknowledge line. Incoming bytes land in a small mailbox of eight 16-bit entries. That is room for exactly one group: sixteen bytes, or four 32-bit instructions.

When the host has sent a group it pulses a separate ready line. The loader then copies the four buffered instructions into program RAM over a single write port. After the eightieth group, the 320-word RAM is full and the loader raises a run output that lets the core start executing. From then on the loader ignores its serial inputs. All host-side inputs are asynchronous to the system clock, so they are synchronised and edge-detected inside the block.

Top module: `serial_prog_loader`

## Requirements
- R1: While reset is held and just after it, `run_o`, `ack_o`, `pram_we_o` and `err_o` are all low, so the block starts in loading mode with execution disabled.
- R2: While loading, `ack_o` follows `req_i` after the input synchroniser delay. Once `run_o` is high, `ack_o` stays low.
- R3: Serial bits are taken on rising edges of `sclk_i`, most significant bit first, and only while the request is high. Dropping the request clears a partly received byte, and edges seen with the request low have no effect.
- R4: Bytes pack big-endian. Instruction k of a group (k = 0..3) is bytes 4k, 4k+1, 4k+2, 4k+3 of that group, and byte 4k occupies bits 31:24.
- R5: A rising edge on `rdy_i` while 16 bytes are buffered writes the group's four instructions on four consecutive clock cycles. They go to addresses 4g, 4g+1, 4g+2, 4g+3 in that order, where g is the index of the group counted from 0.
- R6: Bytes that arrive after the mailbox already holds 16 bytes, and before the group is committed, are discarded.
- R7: A rising edge on `rdy_i` with fewer than 16 bytes buffered writes nothing and discards the partial group. It also sets `err_o`, which stays high until reset.
- R8: The cycle after address 319 is written, `run_o` goes high, and it stays high until reset.
- R9: After `run_o` is high, serial bytes and ready pulses cause no write to program RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdat_i | input | 1 | Host serial data, asynchronous |
| req_i | input | 1 | Host transfer request |
| rdy_i | input | 1 | Host strobe: commit the buffered group |
| ack_o | output | 1 | Acknowledge of the host request |
| pram_we_o | output | 1 | Program RAM write enable |
| pram_addr_o | output | 9 | Program RAM word address |
| pram_data_o | output | 32 | Program RAM write data |
| run_o | output | 1 | Loading complete; core may execute |
| err_o | output | 1 | Sticky flag for a commit with fewer than 16 bytes |

## Verification
The hardest state to reach from the ports is the end of the load. Getting there needs 80 complete groups, and the group counter wraps into the run state only on the very last word. The stimulus therefore streams the whole program with a compressed serial clock of six system cycles per bit. It places the irregular cases early, so that every later group checks they left nothing behind. Those cases are a partial group with a premature ready, a byte cut off by a dropped request, ignored edges while the request is low, and a seventeenth byte. After the load, a further group and ready pulse check that the running state is final.

// File: rtl/sml_pkg.sv
package sml_pkg;

    // Phases of the group commit controller
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_WRITE = 2'd1,
        LD_RUN   = 2'd2
    } ld_state_e;

    // Word address of entry widx inside group grp
    function automatic int unsigned word_addr(int unsigned grp, int unsigned widx,
                                              int unsigned per_grp);
        return grp * per_grp + widx;
    endfunction

endpackage

// File: rtl/sml_sync.sv
module sml_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sml_rx.sv
module sml_rx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sclk_rise,
    input  logic          sdat,
    output logic          byte_vld,
    output logic [BW-1:0] byte_o
);
    localparam int CW = $clog2(BW);

    logic [BW-1:0] shift_q;
    logic [CW-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            bit_q    <= '0;
            byte_vld <= 1'b0;
            byte_o   <= '0;
        end else if (!en) begin
            bit_q    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (sclk_rise) begin
                shift_q <= {shift_q[BW-2:0], sdat};
                bit_q   <= bit_q + 1'b1;
                if (bit_q == CW'(BW-1)) begin
                    byte_vld <= 1'b1;
                    byte_o   <= {shift_q[BW-2:0], sdat};
                end
            end
        end
    end

    // R3
    byte_single_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R3
    byte_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(en));
endmodule

// File: rtl/sml_mailbox.sv
module sml_mailbox #(
    parameter int BW      = 8,
    parameter int ENT_W   = 16,
    parameter int ENTRIES = 8,
    parameter int WORD_W  = 32,
    parameter int WPG     = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_vld,
    input  logic [BW-1:0]          wr_byte,
    input  logic                   clear,
    input  logic [$clog2(WPG)-1:0] rd_idx,
    output logic                   full,
    output logic [WORD_W-1:0]      rd_word
);
    localparam int BYTES = ENTRIES * ENT_W / BW;
    localparam int BPE   = ENT_W / BW;
    localparam int EPW   = WORD_W / ENT_W;
    localparam int CW    = $clog2(BYTES + 1);
    localparam int EW    = $clog2(ENTRIES);

    logic [ENT_W-1:0] ent_q [ENTRIES];
    logic [CW-1:0]    cnt_q;
    logic [EW-1:0]    wr_ent;
    int unsigned      wr_slot;
    logic             accept;

    assign full   = (cnt_q == CW'(BYTES));
    assign accept = wr_vld && !full && !clear;

    always_comb begin
        wr_ent  = EW'(int'(cnt_q) / BPE);
        wr_slot = int'(cnt_q) % BPE;
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (accept)
            ent_q[wr_ent][ENT_W-1 - wr_slot*BW -: BW] <= wr_byte;
    end

    always_comb begin
        for (int j = 0; j < EPW; j++)
            rd_word[WORD_W-1 - j*ENT_W -: ENT_W] = ent_q[EW'(int'(rd_idx)*EPW + j)];
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BYTES));

    // R6
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_vld && !clear) |=> full);
endmodule

// File: rtl/sml_commit.sv
module sml_commit
    import sml_pkg::*;
#(
    parameter int NWORDS = 320,
    parameter int WPG    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rdy_rise,
    input  logic                      full,
    output logic                      we,
    output logic [$clog2(NWORDS)-1:0] addr,
    output logic [$clog2(WPG)-1:0]    rd_idx,
    output logic                      mb_clear,
    output logic                      run,
    output logic                      err
);
    localparam int NGRP = NWORDS / WPG;
    localparam int GW   = $clog2(NGRP);
    localparam int IW   = $clog2(WPG);
    localparam int AW   = $clog2(NWORDS);

    ld_state_e     st_q;
    logic [GW-1:0] grp_q;
    logic [IW-1:0] widx_q;
    logic          err_q;
    logic          last_word, last_grp;

    assign last_word = (widx_q == IW'(WPG-1));
    assign last_grp  = (grp_q == GW'(NGRP-1));

    always_comb begin
        we       = (st_q == LD_WRITE);
        run      = (st_q == LD_RUN);
        rd_idx   = widx_q;
        addr     = AW'(word_addr(int'(grp_q), int'(widx_q), WPG));
        mb_clear = (we && last_word) || (st_q == LD_IDLE && rdy_rise && !full);
        err      = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LD_IDLE;
            grp_q  <= '0;
            widx_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                LD_IDLE: begin
                    if (rdy_rise) begin
                        if (full) begin
                            st_q   <= LD_WRITE;
                            widx_q <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                LD_WRITE: begin
                    widx_q <= widx_q + 1'b1;
                    if (last_word) begin
                        widx_q <= '0;
                        if (last_grp) begin
                            st_q <= LD_RUN;
                        end else begin
                            grp_q <= grp_q + 1'b1;
                            st_q  <= LD_IDLE;
                        end
                    end
                end
                LD_RUN:  st_q <= LD_RUN;
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> run);

    // R9
    no_write_running_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> !we);

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(addr) < NWORDS));

    // R5
    burst_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !last_word) |=> we);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(!full && rdy_rise));
endmodule

// File: rtl/serial_prog_loader.sv
module serial_prog_loader #(
    parameter int NWORDS      = 320,
    parameter int WORD_W      = 32,
    parameter int WPG         = 4,
    parameter int BYTE_W      = 8,
    parameter int ENT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sclk_i,
    input  logic                      sdat_i,
    input  logic                      req_i,
    input  logic                      rdy_i,
    output logic                      ack_o,
    output logic                      pram_we_o,
    output logic [$clog2(NWORDS)-1:0] pram_addr_o,
    output logic [WORD_W-1:0]         pram_data_o,
    output logic                      run_o,
    output logic                      err_o
);
    localparam int ENTRIES = WPG * WORD_W / ENT_W;
    localparam int IW      = $clog2(WPG);

    logic [3:0]        sync_q;
    logic              sclk_s, sdat_s, req_s, rdy_s;
    logic              sclk_d, rdy_d;
    logic              sclk_rise, rdy_rise;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              mb_full, mb_clear;
    logic [IW-1:0]     rd_idx;
    logic              run;

    sml_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rdy_i, req_i, sdat_i, sclk_i}),
        .q   (sync_q)
    );

    assign {rdy_s, req_s, sdat_s, sclk_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            rdy_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            rdy_d  <= rdy_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_d;
    assign rdy_rise  = rdy_s && !rdy_d && !run;

    sml_rx #(.BW(BYTE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (req_s && !run),
        .sclk_rise (sclk_rise),
        .sdat      (sdat_s),
        .byte_vld  (byte_vld),
        .byte_o    (byte_val)
    );

    sml_mailbox #(
        .BW(BYTE_W), .ENT_W(ENT_W), .ENTRIES(ENTRIES), .WORD_W(WORD_W), .WPG(WPG)
    ) u_mbox (
        .clk     (clk),
        .rst     (rst),
        .wr_vld  (byte_vld),
        .wr_byte (byte_val),
        .clear   (mb_clear),
        .rd_idx  (rd_idx),
        .full    (mb_full),
        .rd_word (pram_data_o)
    );

    sml_commit #(.NWORDS(NWORDS), .WPG(WPG)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .rdy_rise (rdy_rise),
        .full     (mb_full),
        .we       (pram_we_o),
        .addr     (pram_addr_o),
        .rd_idx   (rd_idx),
        .mb_clear (mb_clear),
        .run      (run),
        .err      (err_o)
    );

    assign run_o = run;
    assign ack_o = req_s && !run;

    // R2
    ack_off_running_chk: assert property (@(posedge clk) disable iff (rst)
        run_o |-> !ack_o);

    // R9
    no_byte_running_chk: assert property (@(posedge clk) disable iff (rst)
        $past(run_o) |-> !byte_vld);
endmodule

// File: tb/test_serial_prog_loader.sv
module test_serial_prog_loader;
    localparam int NWORDS = 320;
    localparam int NGRP   = NWORDS / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_i = 1'b0, sdat_i = 1'b0, req_i = 1'b0, rdy_i = 1'b0;
    logic        ack_o, pram_we_o, run_o, err_o;
    logic [8:0]  pram_addr_o;
    logic [31:0] pram_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit exp_run = 1'b0;
    int burst  = 0;
    logic [40:0] exp_q [$];   // {addr, data}

    always #4 clk = ~clk;     // 125 MHz

    serial_prog_loader i_serial_prog_loader (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdat_i(sdat_i), .req_i(req_i),
        .rdy_i(rdy_i), .ack_o(ack_o), .pram_we_o(pram_we_o),
        .pram_addr_o(pram_addr_o), .pram_data_o(pram_data_o),
        .run_o(run_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(input int g, input int i);
        return 8'((g * 29 + i * 53 + 7) ^ (g >> 1) ^ (i << 4));
    endfunction

    task automatic send_bit(input logic b);
        sdat_i = b; tick(3);
        sclk_i = 1'b1; tick(3);
        sclk_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic pulse_ready();
        rdy_i = 1'b1; tick(4);
        rdy_i = 1'b0; tick(12);
    endtask

    // Sends group g's bytes, queues the expected words (R4, R5), commits it
    task automatic load_group(input int g, input bit extra);
        logic [7:0] b [16];
        for (int i = 0; i < 16; i++) begin
            b[i] = pat(g, i);
            send_byte(b[i]);
        end
        if (extra) send_byte(8'hA5);   // R6: seventeenth byte must vanish
        for (int k = 0; k < 4; k++)
            exp_q.push_back({9'(4*g + k), b[4*k], b[4*k+1], b[4*k+2], b[4*k+3]});
        pulse_ready();
    endtask

    // Reference model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(run_o == exp_run, "R8 run_o", 64'(run_o), 64'(exp_run));
            if (pram_we_o) begin
                burst++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write addr", 64'(pram_addr_o), 64'h0);
                end else begin
                    logic [40:0] e;
                    e = exp_q.pop_front();
                    check(pram_addr_o == e[40:32], "R5 address",
                          64'(pram_addr_o), 64'(e[40:32]));
                    check(pram_data_o == e[31:0], "R4 data",
                          64'(pram_data_o), 64'(e[31:0]));
                    if (e[40:32] == 9'(NWORDS-1)) exp_run = 1'b1;
                end
            end else begin
                if (burst != 0)
                    check(burst == 4, "R5 burst length", 64'(burst), 64'd4);
                burst = 0;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(5);
        // R1 reset state
        check({run_o, ack_o, pram_we_o, err_o} == 4'b0, "R1 reset outputs",
              64'({run_o, ack_o, pram_we_o, err_o}), 64'h0);
        rst = 1'b0;
        tick(3);
        check({run_o, ack_o, pram_we_o, err_o} == 4'b0, "R1 after reset",
              64'({run_o, ack_o, pram_we_o, err_o}), 64'h0);

        // R3: edges with request low are ignored
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        req_i = 1'b1; tick(4);
        check(ack_o == 1'b1, "R2 ack follows request", 64'(ack_o), 64'd1);
        load_group(0, 1'b0);

        // R7: premature ready
        for (int i = 0; i < 5; i++) send_byte(8'h3C);
        check(err_o == 1'b0, "R7 err before strobe", 64'(err_o), 64'd0);
        pulse_ready();
        check(err_o == 1'b1, "R7 err set", 64'(err_o), 64'd1);

        // R3: partial byte cut by dropping the request
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        req_i = 1'b0; tick(4);
        check(ack_o == 1'b0, "R2 ack drops", 64'(ack_o), 64'd0);
        req_i = 1'b1; tick(4);
        load_group(1, 1'b0);

        // R6: extra byte before ready
        load_group(2, 1'b1);
        check(err_o == 1'b1, "R7 err sticky", 64'(err_o), 64'd1);

        for (int g = 3; g < NGRP; g++) load_group(g, 1'b0);
        tick(4);
        check(run_o == 1'b1, "R8 run after last group", 64'(run_o), 64'd1);
        check(exp_q.size() == 0, "R5 all words written", 64'(exp_q.size()), 64'd0);

        // R9: inputs ignored once running
        for (int i = 0; i < 16; i++) send_byte(pat(7, i));
        pulse_ready();
        check(ack_o == 1'b0, "R2 ack low while running", 64'(ack_o), 64'd0);
        check(run_o == 1'b1, "R9 run holds", 64'(run_o), 64'd1);
        check(exp_q.size() == 0, "R9 queue empty", 64'(exp_q.size()), 64'd0);
        tick(4);
        finish_run();
    end
endmodule